// File: doc/BRIEF.md
# Maskable Interrupt Enable Controller

This block sits beside a small 8-bit processor core and turns four event sources into a single prioritised interrupt request. It latches an edge on an external interrupt pin, the overflow pulses of two timers and the conversion-complete pulse of an analog-to-digital converter into request flags. Each source has its own enable bit, and a master enable bit gates all of them at once.

The core sees `irq_req` together with a 2-bit vector index. When it accepts the interrupt (`irq_ack`), the block clears the master enable so that no nested interrupt can be taken, and it clears the flag of the source that was vectored. When the core executes its return-from-interrupt (`irq_ret`), the master enable is set again. No context of any kind is saved by this block. Software reaches the two control registers through a byte-write port and through single-bit set and clear operations. The active edge of the external pin is chosen by a polarity input, which is driven from a system control register outside this block.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset, every enable bit, the master enable and every flag are 0, both registers read 0 and `irq_req` is low.
- R2: Register 0 (`reg_sel`=0) holds the master enable in bit 0 and the enables for external, timer 0, timer 1 and A/D in bits 1 to 4. Register 1 (`reg_sel`=1) holds the flags for external, timer 0, timer 1 and A/D in bits 0 to 3. `bus_op`=01 writes `wdata` as a whole byte. The bits that are not used ignore writes and always read 0.
- R3: `bus_op`=10 sets, and `bus_op`=11 clears, only the bit selected by `bit_idx` in the selected register. All other bits keep their values. `bus_op`=00 changes nothing.
- R4: A one-cycle pulse on `tmr0_ovf`, `tmr1_ovf` or `adc_done` sets the matching flag on the next clock, whatever the enables are. An event wins over a software clear or an acknowledge clear of the same flag in the same cycle.
- R5: The external flag is set SYNC_STAGES+1 clocks after the pin changes to its active level: rising when `ext_fall_sel`=0, falling when it is 1. A change in the other direction sets nothing.
- R6: `irq_req` is high exactly when the master enable is 1 and at least one source has both its flag and its enable set. With the master enable at 0 it is never high.
- R7: `irq_vec` names the highest-priority pending enabled source. The priority order is external (0), timer 0 (1), timer 1 (2), A/D (3).
- R8: `irq_ack` while `irq_req` is high clears the master enable and the vectored source's flag on the next clock, and leaves the other flags alone. `irq_ack` while `irq_req` is low has no effect.
- R9: `irq_ret` sets the master enable on the next clock, overriding a software write of that bit. An accepted `irq_ack` in the same cycle takes precedence, and the master enable then ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_fall_sel | input | 1 | Active edge of ext_pin: 0 rising, 1 falling |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | A/D conversion-complete pulse |
| reg_sel | input | 1 | Register select: 0 enables, 1 flags |
| bus_op | input | 2 | 00 idle, 01 byte write, 10 bit set, 11 bit clear |
| bit_idx | input | $clog2(DATA_W) | Bit position for set and clear |
| wdata | input | DATA_W | Byte write data |
| rdata | output | DATA_W | Contents of the selected register |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Core returns from the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Index of the vectored source |

## Verification
The bound checker watches several rules on every clock. It checks that no request is raised while the master enable is off and that a request always has a pending enabled source behind it. It checks that the vector points at the lowest-numbered pending source, that an accepted interrupt clears the master enable and the vectored flag, that a return sets the master enable, and that each timer or converter event leaves its flag set. Some behaviour is shown only by the bench's scenarios. These are the synchronizer latency and the polarity choice on the external pin, the masking of unused register bits, the single-bit operations, and the precedence when an acknowledge, a return and a software write meet in one cycle. The bench follows every cycle of a long random run against its own register model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned VEC_W   = $clog2(NUM_SRC);

   localparam int unsigned SRC_EXT  = 0;
   localparam int unsigned SRC_TMR0 = 1;
   localparam int unsigned SRC_TMR1 = 2;
   localparam int unsigned SRC_ADC  = 3;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } bus_op_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_evt
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
         prev_q  <= chain_q[LAST];
      end
   end

   always_comb begin
      if (fall_sel) edge_evt = prev_q & ~chain_q[LAST];
      else          edge_evt = ~prev_q & chain_q[LAST];
   end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_sel,
   input  logic [1:0]                bus_op,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [NUM_SRC-1:0]        src_evt,
   input  logic                      take,
   input  logic [VEC_W-1:0]          take_vec,
   input  logic                      ret,
   output logic                      master,
   output logic [NUM_SRC-1:0]        en,
   output logic [NUM_SRC-1:0]        flag,
   output logic [DATA_W-1:0]         rdata
);
   localparam int unsigned IDX_W  = $clog2(DATA_W);
   localparam int unsigned EN_LSB = 1;
   localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'((1 << (NUM_SRC + 1)) - 1);
   localparam logic [DATA_W-1:0] FLG_MASK = DATA_W'((1 << NUM_SRC) - 1);

   if (DATA_W < NUM_SRC + 1) begin : g_bad_width
      $error("irq_regfile: DATA_W too small for the enable layout");
   end
   if ((1 << IDX_W) != DATA_W) begin : g_bad_pow2
      $error("irq_regfile: DATA_W must be a power of two");
   end

   logic [DATA_W-1:0] ctl_q, flg_q, ctl_d, flg_d;
   bus_op_e           op;

   assign op = bus_op_e'(bus_op);

   function automatic logic [DATA_W-1:0] apply_op(input logic [DATA_W-1:0] cur,
                                                  input bus_op_e           kind,
                                                  input logic [IDX_W-1:0]  idx,
                                                  input logic [DATA_W-1:0] wd);
      logic [DATA_W-1:0] res;
      res = cur;
      case (kind)
         OP_WRITE: res      = wd;
         OP_SET:   res[idx] = 1'b1;
         OP_CLEAR: res[idx] = 1'b0;
         default:  res      = cur;
      endcase
      return res;
   endfunction

   always_comb begin
      ctl_d = reg_sel ? ctl_q : apply_op(ctl_q, op, bit_idx, wdata);
      flg_d = reg_sel ? apply_op(flg_q, op, bit_idx, wdata) : flg_q;
      ctl_d = ctl_d & CTL_MASK;
      flg_d = flg_d & FLG_MASK;
      if (take) begin
         ctl_d[0]        = 1'b0;
         flg_d[take_vec] = 1'b0;
      end else if (ret) begin
         ctl_d[0] = 1'b1;
      end
      flg_d[NUM_SRC-1:0] = flg_d[NUM_SRC-1:0] | src_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         flg_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         flg_q <= flg_d;
      end
   end

   assign master = ctl_q[0];
   assign en     = ctl_q[EN_LSB +: NUM_SRC];
   assign flag   = flg_q[NUM_SRC-1:0];
   assign rdata  = reg_sel ? flg_q : ctl_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     pend,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end
   assign any = |pend;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ext_pin,
   input  logic                      ext_fall_sel,
   input  logic                      tmr0_ovf,
   input  logic                      tmr1_ovf,
   input  logic                      adc_done,
   input  logic                      reg_sel,
   input  logic [1:0]                bus_op,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   input  logic                      irq_ack,
   input  logic                      irq_ret,
   output logic                      irq_req,
   output logic [1:0]                irq_vec
);
   logic               ext_evt;
   logic [NUM_SRC-1:0] src_evt;
   logic [NUM_SRC-1:0] en_vec, flag_vec, pend_vec;
   logic               master, pend_any, take;
   logic [VEC_W-1:0]   win_idx;

   irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (ext_fall_sel),
      .edge_evt (ext_evt)
   );

   always_comb begin
      src_evt           = '0;
      src_evt[SRC_EXT]  = ext_evt;
      src_evt[SRC_TMR0] = tmr0_ovf;
      src_evt[SRC_TMR1] = tmr1_ovf;
      src_evt[SRC_ADC]  = adc_done;
   end

   irq_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_sel  (reg_sel),
      .bus_op   (bus_op),
      .bit_idx  (bit_idx),
      .wdata    (wdata),
      .src_evt  (src_evt),
      .take     (take),
      .take_vec (win_idx),
      .ret      (irq_ret),
      .master   (master),
      .en       (en_vec),
      .flag     (flag_vec),
      .rdata    (rdata)
   );

   assign pend_vec = en_vec & flag_vec;

   irq_prio #(.N(NUM_SRC), .IDX_W(VEC_W)) u_prio (
      .pend (pend_vec),
      .any  (pend_any),
      .idx  (win_idx)
   );

   assign irq_req = master & pend_any;
   assign irq_vec = win_idx;
   assign take    = irq_ack & irq_req;
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk
   import irq_ctrl_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               irq_ack,
   input logic               irq_ret,
   input logic               irq_req,
   input logic [VEC_W-1:0]   irq_vec,
   input logic               master,
   input logic [NUM_SRC-1:0] en,
   input logic [NUM_SRC-1:0] flag,
   input logic [NUM_SRC-1:0] src_evt
);
   logic [NUM_SRC-1:0] pend, below;
   logic               accepted;

   assign pend     = en & flag;
   assign below    = (NUM_SRC'(1) << irq_vec) - NUM_SRC'(1);
   assign accepted = irq_ack & irq_req;

   AST_NO_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> !irq_req); // R6
   AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend != '0)); // R6
   AST_VEC_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend[irq_vec] && ((pend & below) == '0))); // R7
   AST_ACK_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> !master); // R8
   AST_ACK_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && !src_evt[irq_vec]) |=> !flag[$past(irq_vec)]); // R8
   AST_RET_RAISES_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !accepted) |=> master); // R9
   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt != '0) |=> ((flag & $past(src_evt)) == $past(src_evt))); // R4
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_ack (irq_ack),
   .irq_ret (irq_ret),
   .irq_req (irq_req),
   .irq_vec (irq_vec),
   .master  (master),
   .en      (en_vec),
   .flag    (flag_vec),
   .src_evt (src_evt)
);

// File: tb/irq_enable_ctrl_tb.sv
`timescale 1ns/1ps
module irq_enable_ctrl_tb;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0, ext_fall_sel = 1'b0;
   logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, adc_done = 1'b0;
   logic       reg_sel = 1'b0;
   logic [1:0] bus_op = 2'b00;
   logic [2:0] bit_idx = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_ack = 1'b0, irq_ret = 1'b0;
   logic       irq_req;
   logic [1:0] irq_vec;

   int checks = 0;
   int fails  = 0;
   bit model_on = 1'b0;
   logic [7:0] m_r0 = 8'h00, m_r1 = 8'h00;

   always #2 clk = ~clk;

   irq_enable_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_fall_sel(ext_fall_sel),
      .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .adc_done(adc_done),
      .reg_sel(reg_sel), .bus_op(bus_op), .bit_idx(bit_idx), .wdata(wdata),
      .rdata(rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_req();
      return m_r0[0] && ((m_r0[4:1] & m_r1[3:0]) != 4'h0);
   endfunction

   function automatic logic [1:0] exp_vec();
      logic [3:0] p;
      p = m_r0[4:1] & m_r1[3:0];
      if (p[0]) return 2'd0;
      if (p[1]) return 2'd1;
      if (p[2]) return 2'd2;
      if (p[3]) return 2'd3;
      return 2'd0;
   endfunction

   task automatic model_update();
      logic [7:0] a, b;
      logic       tk;
      logic [1:0] v;
      a = m_r0; b = m_r1;
      tk = irq_ack && exp_req();
      v = exp_vec();
      case (bus_op)
         2'b01: if (reg_sel) b = wdata; else a = wdata;
         2'b10: if (reg_sel) b[bit_idx] = 1'b1; else a[bit_idx] = 1'b1;
         2'b11: if (reg_sel) b[bit_idx] = 1'b0; else a[bit_idx] = 1'b0;
         default: ;
      endcase
      a = a & 8'h1F;
      b = b & 8'h0F;
      if (tk) begin a[0] = 1'b0; b[v] = 1'b0; end
      else if (irq_ret) a[0] = 1'b1;
      b[1] = b[1] | tmr0_ovf;
      b[2] = b[2] | tmr1_ovf;
      b[3] = b[3] | adc_done;
      m_r0 = a; m_r1 = b;
   endtask

   task automatic rd(input logic s, output logic [7:0] v);
      reg_sel = s;
      #0.1;
      v = rdata;
   endtask

   task automatic idle_inputs();
      tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; adc_done = 1'b0;
      bus_op = 2'b00; irq_ack = 1'b0; irq_ret = 1'b0;
   endtask

   task automatic compare_model();
      logic [7:0] v;
      chk("R6 irq_req vs model", irq_req, exp_req());
      if (exp_req()) chk("R7 irq_vec vs model", irq_vec, exp_vec());
      rd(1'b0, v); chk("R2 R3 R8 R9 enable register vs model", v, m_r0);
      rd(1'b1, v); chk("R2 R3 R4 R8 flag register vs model", v, m_r1);
   endtask

   // inputs already driven at a falling edge; advance one cycle
   task automatic tick();
      if (model_on) model_update();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      if (model_on) compare_model();
   endtask

   task automatic op(input logic s, input logic [1:0] o, input logic [2:0] b, input logic [7:0] d);
      reg_sel = s; bus_op = o; bit_idx = b; wdata = d;
      tick();
   endtask

   task automatic do_reset();
      idle_inputs();
      ext_pin = 1'b0; ext_fall_sel = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_r0 = 8'h00; m_r1 = 8'h00;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      do_reset();
      // R1
      rd(1'b0, v); chk("R1 enable register after reset", v, 8'h00);
      rd(1'b1, v); chk("R1 flag register after reset", v, 8'h00);
      chk("R1 irq_req after reset", irq_req, 1'b0);
      model_on = 1'b1;

      // R2: unused bits ignore writes
      op(1'b0, 2'b01, 3'd0, 8'hFF);
      rd(1'b0, v); chk("R2 enable register masks unused bits", v, 8'h1F);
      op(1'b1, 2'b01, 3'd0, 8'hFF);
      rd(1'b1, v); chk("R2 flag register masks unused bits", v, 8'h0F);
      op(1'b0, 2'b01, 3'd0, 8'h00);
      op(1'b1, 2'b01, 3'd0, 8'h00);

      // R3: single-bit operations
      op(1'b0, 2'b10, 3'd2, 8'hFF);
      rd(1'b0, v); chk("R3 bit set", v, 8'h04);
      op(1'b0, 2'b10, 3'd0, 8'h00);
      rd(1'b0, v); chk("R3 second bit set", v, 8'h05);
      op(1'b0, 2'b11, 3'd2, 8'hFF);
      rd(1'b0, v); chk("R3 bit clear", v, 8'h01);
      op(1'b0, 2'b10, 3'd7, 8'h00);
      rd(1'b0, v); chk("R3 set of unused bit", v, 8'h01);
      op(1'b0, 2'b00, 3'd3, 8'hFF);
      rd(1'b0, v); chk("R3 idle op changes nothing", v, 8'h01);
      op(1'b0, 2'b01, 3'd0, 8'h00);

      // R4: events set flags regardless of enables, beat a clear
      tmr1_ovf = 1'b1; tick();
      rd(1'b1, v); chk("R4 timer 1 flag with enables off", v, 8'h04);
      chk("R4 no request with enables off", irq_req, 1'b0);
      reg_sel = 1'b1; bus_op = 2'b11; bit_idx = 3'd2; tmr1_ovf = 1'b1; tick();
      rd(1'b1, v); chk("R4 event beats software clear", v, 8'h04);
      tmr0_ovf = 1'b1; adc_done = 1'b1; tick();
      op(1'b1, 2'b10, 3'd0, 8'h00);
      rd(1'b1, v); chk("R4 all flags set", v, 8'h0F);

      // R6 / R7 / R8 / R9
      op(1'b0, 2'b01, 3'd0, 8'h1E);
      chk("R6 master off blocks request", irq_req, 1'b0);
      op(1'b0, 2'b10, 3'd0, 8'h00);
      chk("R6 request with master on", irq_req, 1'b1);
      chk("R7 external has top priority", irq_vec, 2'd0);
      irq_ack = 1'b1; tick();
      rd(1'b0, v); chk("R8 ack clears master", v, 8'h1E);
      rd(1'b1, v); chk("R8 ack clears only vectored flag", v, 8'h0E);
      chk("R8 request drops after ack", irq_req, 1'b0);
      irq_ack = 1'b1; tick();
      rd(1'b1, v); chk("R8 ack without request ignored", v, 8'h0E);
      irq_ret = 1'b1; tick();
      chk("R9 return restores request", irq_req, 1'b1);
      chk("R7 timer 0 next", irq_vec, 2'd1);
      irq_ack = 1'b1; irq_ret = 1'b1; tick();
      rd(1'b0, v); chk("R9 accepted ack wins over return", v, 8'h1E);
      reg_sel = 1'b0; bus_op = 2'b11; bit_idx = 3'd0; irq_ret = 1'b1; tick();
      rd(1'b0, v); chk("R9 return overrides software clear", v, 8'h1F);
      chk("R7 timer 1 next", irq_vec, 2'd2);
      op(1'b0, 2'b11, 3'd3, 8'h00);
      chk("R7 A/D when timer 1 disabled", irq_vec, 2'd3);
      reg_sel = 1'b0; irq_ack = 1'b1; adc_done = 1'b1; tick();
      rd(1'b1, v); chk("R4 event beats ack clear", v, 8'h0C);

      // R5: external edge detection, model off
      model_on = 1'b0;
      do_reset();
      reg_sel = 1'b1;
      ext_pin = 1'b1;
      for (int i = 0; i < SYNC; i++) begin
         tick(); rd(1'b1, v); chk("R5 rising edge not yet visible", v[0], 1'b0);
      end
      tick(); rd(1'b1, v); chk("R5 rising edge latched", v[0], 1'b1);
      op(1'b1, 2'b11, 3'd0, 8'h00);
      ext_pin = 1'b0;
      repeat (SYNC + 3) tick();
      rd(1'b1, v); chk("R5 falling edge ignored in rising mode", v[0], 1'b0);
      ext_fall_sel = 1'b1;
      ext_pin = 1'b1;
      repeat (SYNC + 3) tick();
      rd(1'b1, v); chk("R5 rising edge ignored in falling mode", v[0], 1'b0);
      ext_pin = 1'b0;
      for (int i = 0; i < SYNC; i++) begin
         tick(); rd(1'b1, v); chk("R5 falling edge not yet visible", v[0], 1'b0);
      end
      tick(); rd(1'b1, v); chk("R5 falling edge latched", v[0], 1'b1);

      // random phase against the model
      do_reset();
      model_on = 1'b1;
      void'($urandom(32'h1234_5678));
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         reg_sel = 1'($urandom_range(0, 1));
         bus_op  = (r < 6) ? 2'b00 : 2'($urandom_range(1, 3));
         bit_idx = 3'($urandom_range(0, 7));
         wdata   = 8'($urandom);
         tmr0_ovf = ($urandom_range(0, 7) == 0);
         tmr1_ovf = ($urandom_range(0, 7) == 0);
         adc_done = ($urandom_range(0, 7) == 0);
         irq_ack  = ($urandom_range(0, 3) == 0);
         irq_ret  = ($urandom_range(0, 7) == 0);
         tick();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule